// File: doc/BRIEF.md
# Constant-Run Stripping Bit Condenser

This block takes a serial stream of bits and cuts it into fixed blocks (12,000 bits by default). It scans every block from its first bit to its last. When it finds a run of identical bits that is long enough to be worth removing, it drops the run from the data path and stores a compact 20-bit description of the run in a small on-chip log. The bits it keeps leave the block one after another, with no gaps. Every bit it keeps is called a payload bit.

When the last bit of a block has been scanned, the block sends a suffix. The suffix holds the stored log entries, oldest first, and then a one-byte end marker. A downstream receiver can then splice the removed runs back in. A flag on the output tells payload bits apart from suffix bits. Both ends of the block use a valid/ready handshake, one bit per transfer.

The block handles only runs of one constant value. Each block is treated on its own: no run, count or log entry carries over from one block into the next.

Top module: `run_strip_condenser`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `log_ovf` is 0.
- R2: Inside a block, a run of at least MIN_RUN identical consecutive bits is left out of the payload when the log has room for it. A run shorter than MIN_RUN passes through unchanged.
- R3: Kept bits leave in input order as consecutive payload transfers, each with `out_sfx` = 0.
- R4: A log entry is 20 bits wide. Bits 19..6 hold the skip count, bits 5..1 hold the run length and bit 0 holds the run value. The skip count is the number of payload bits sent since the previous entry of the same block, or since the block start for the first entry.
- R5: A run is cut into pieces as it arrives. Every 31 consecutive bits of a run form one piece of length 31. The bits left over at the end form one more piece, which is stripped only if it holds at least MIN_RUN bits and is otherwise passed through.
- R6: After the last payload bit of a block, the block sends each log entry in the order it was stored, most significant bit first, with `out_sfx` = 1. It then sends the marker 8'hA5, most significant bit first, also with `out_sfx` = 1.
- R7: A run that qualifies for stripping while the log already holds LOG_DEPTH entries is passed through as payload bits. At that point `log_ovf` rises. It stays high until the last marker bit has been loaded into the output register, and then it falls.
- R8: Runs never span two blocks. In the cycle after the last bit of a block is accepted, `in_ready` is low.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bit` and `out_sfx` hold their values.
- R10: No input bit is accepted while the suffix of a block is being sent, up to the loading of its last marker bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bit is offered |
| in_bit | input | 1 | Input data bit |
| in_ready | output | 1 | Block accepts the offered bit |
| out_valid | output | 1 | Output bit is available |
| out_bit | output | 1 | Output data bit |
| out_sfx | output | 1 | 1 for a suffix bit (log entry or marker), 0 for a payload bit |
| out_ready | input | 1 | Sink takes the output bit |
| log_ovf | output | 1 | Log overflowed in the current block |

## Verification
Each kind of internal fault shows up at the ports in its own way:

- A fault in the run counter or in the piece boundary changes how many payload bits come out. Every later log entry and the position of the marker then move too.
- A wrong skip count shows up in the first suffix entry that follows it.
- A fault in the log storage or in its read order shows up while the suffix is sent, within the 20 transfers of the entry that is affected.
- A wrong overflow decision changes both the payload length and the state of `log_ovf` when the suffix starts.

The bench computes the whole expected output of each block from the requirements alone. It checks that output under both a steady sink and a stalling sink.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int SKIP_W = 14;
  localparam int LEN_W  = 5;
  localparam int TUP_W  = SKIP_W + LEN_W + 1;
  localparam int MARK_W = 8;
  localparam logic [LEN_W-1:0]  LEN_MAX  = '1;
  localparam logic [MARK_W-1:0] END_MARK = 8'hA5;

  typedef enum logic [2:0] {
    ST_SCAN, ST_RESOLVE, ST_EMIT, ST_FETCH, ST_LOGOUT, ST_MARK
  } rsc_state_e;

  typedef struct packed {
    logic [SKIP_W-1:0] skip;
    logic [LEN_W-1:0]  len;
    logic              val;
  } rsc_tuple_t;
endpackage

// File: rtl/rsc_log_ram.sv
module rsc_log_ram
  import rsc_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int MIN_LEN = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  rsc_tuple_t    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [TUP_W-1:0] rd_data
);
  logic [TUP_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  // R2
  log_len_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data.len != '0) && (32'(wr_data.len) >= MIN_LEN));
endmodule

// File: rtl/rsc_out_stage.sv
module rsc_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic ld,
  input  logic ld_bit,
  input  logic ld_sfx,
  output logic space,
  input  logic out_ready,
  output logic out_valid,
  output logic out_bit,
  output logic out_sfx
);
  assign space = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_sfx   <= 1'b0;
    end else if (space) begin
      out_valid <= ld;
      out_bit   <= ld_bit;
      out_sfx   <= ld_sfx;
    end
  end

  // R9
  out_stable_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_bit) && $stable(out_sfx));
endmodule

// File: rtl/run_strip_condenser.sv
module run_strip_condenser
  import rsc_pkg::*;
#(
  parameter int BLOCK_BITS = 12000,
  parameter int MIN_RUN    = 8,
  parameter int LOG_DEPTH  = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic out_valid,
  output logic out_bit,
  output logic out_sfx,
  input  logic out_ready,
  output logic log_ovf
);
  localparam int POS_W  = $clog2(BLOCK_BITS);
  localparam int LCNT_W = $clog2(LOG_DEPTH + 1);
  localparam int LA_W   = $clog2(LOG_DEPTH);
  localparam int BI_W   = $clog2(TUP_W);
  localparam logic [POS_W-1:0]  LAST_POS = POS_W'(BLOCK_BITS - 1);
  localparam logic [LEN_W-1:0]  MIN_L    = LEN_W'(MIN_RUN);
  localparam logic [LCNT_W-1:0] DEPTH_L  = LCNT_W'(LOG_DEPTH);

  rsc_state_e        state;
  logic [POS_W-1:0]  pos;
  logic              run_val, fin_val;
  logic [LEN_W-1:0]  run_cnt, fin_cnt;
  logic              blk_end;
  logic [SKIP_W-1:0] skip_cnt;
  logic [LCNT_W-1:0] log_cnt;
  logic [LA_W-1:0]   rd_idx;
  logic [BI_W-1:0]   bit_i;
  logic              ovf;
  logic [TUP_W-1:0]  rd_q;

  logic accept, last, same, diff, chunk, elig, full, wr_en, has_log, res_done;
  logic ospace, ld, ld_bit, ld_sfx;
  rsc_tuple_t wr_tup;

  assign in_ready = (state == ST_SCAN);
  assign log_ovf  = ovf;
  assign accept   = in_ready && in_valid;
  assign last     = (pos == LAST_POS);
  assign same     = (run_cnt != '0) && (in_bit == run_val);
  assign diff     = (run_cnt != '0) && (in_bit != run_val);
  assign chunk    = same && (run_cnt == LEN_MAX - 1'b1);
  assign elig     = (fin_cnt >= MIN_L);
  assign full     = (log_cnt == DEPTH_L);
  assign wr_en    = (state == ST_RESOLVE) && elig && !full;
  assign has_log  = (log_cnt != '0) || wr_en;
  assign res_done = wr_en || ((state == ST_EMIT) && ospace && (fin_cnt == LEN_W'(1)));
  assign wr_tup   = '{skip: skip_cnt, len: fin_cnt, val: fin_val};

  always_comb begin
    ld = 1'b0; ld_bit = 1'b0; ld_sfx = 1'b0;
    case (state)
      ST_EMIT:   begin ld = ospace; ld_bit = fin_val;                   end
      ST_LOGOUT: begin ld = ospace; ld_bit = rd_q[bit_i];   ld_sfx = 1'b1; end
      ST_MARK:   begin ld = ospace; ld_bit = END_MARK[bit_i[2:0]]; ld_sfx = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_SCAN; pos <= '0; run_val <= 1'b0; run_cnt <= '0;
      fin_val <= 1'b0; fin_cnt <= '0; blk_end <= 1'b0; skip_cnt <= '0;
      log_cnt <= '0; rd_idx <= '0; bit_i <= '0; ovf <= 1'b0;
    end else begin
      case (state)
        ST_SCAN: if (accept) begin
          pos <= last ? '0 : pos + 1'b1;
          if (diff) begin
            fin_val <= run_val; fin_cnt <= run_cnt;
            run_val <= in_bit;  run_cnt <= LEN_W'(1);
            blk_end <= last;    state   <= ST_RESOLVE;
          end else if (chunk) begin
            fin_val <= run_val; fin_cnt <= LEN_MAX; run_cnt <= '0;
            blk_end <= last;    state   <= ST_RESOLVE;
          end else if (last) begin
            fin_val <= in_bit;
            fin_cnt <= same ? run_cnt + 1'b1 : LEN_W'(1);
            run_cnt <= '0; blk_end <= 1'b1; state <= ST_RESOLVE;
          end else begin
            run_val <= in_bit;
            run_cnt <= same ? run_cnt + 1'b1 : LEN_W'(1);
          end
        end
        ST_RESOLVE: begin
          if (wr_en) begin
            log_cnt  <= log_cnt + 1'b1;
            skip_cnt <= '0;
          end else begin
            if (elig) ovf <= 1'b1;
            state <= ST_EMIT;
          end
        end
        ST_EMIT: if (ospace) begin
          fin_cnt  <= fin_cnt - 1'b1;
          skip_cnt <= skip_cnt + 1'b1;
        end
        ST_FETCH: begin
          bit_i <= BI_W'(TUP_W - 1);
          state <= ST_LOGOUT;
        end
        ST_LOGOUT: if (ospace) begin
          if (bit_i == '0) begin
            if (LCNT_W'(rd_idx) + 1'b1 == log_cnt) begin
              bit_i <= BI_W'(MARK_W - 1);
              state <= ST_MARK;
            end else begin
              rd_idx <= rd_idx + 1'b1;
              state  <= ST_FETCH;
            end
          end else begin
            bit_i <= bit_i - 1'b1;
          end
        end
        ST_MARK: if (ospace) begin
          if (bit_i == '0) begin
            state <= ST_SCAN; log_cnt <= '0; ovf <= 1'b0; skip_cnt <= '0;
          end else begin
            bit_i <= bit_i - 1'b1;
          end
        end
        default: state <= ST_SCAN;
      endcase

      if (res_done) begin
        if (blk_end && run_cnt != '0) begin
          fin_val <= run_val; fin_cnt <= run_cnt; run_cnt <= '0;
          state   <= ST_RESOLVE;
        end else if (blk_end) begin
          blk_end <= 1'b0;
          rd_idx  <= '0;
          if (has_log) begin
            state <= ST_FETCH;
          end else begin
            bit_i <= BI_W'(MARK_W - 1);
            state <= ST_MARK;
          end
        end else begin
          state <= ST_SCAN;
        end
      end
    end
  end

  rsc_log_ram #(.DEPTH(LOG_DEPTH), .MIN_LEN(MIN_RUN)) u_log (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(log_cnt[LA_W-1:0]),
    .wr_data(wr_tup), .rd_addr(rd_idx), .rd_data(rd_q)
  );

  rsc_out_stage u_out (
    .clk(clk), .rst(rst), .ld(ld), .ld_bit(ld_bit), .ld_sfx(ld_sfx),
    .space(ospace), .out_ready(out_ready), .out_valid(out_valid),
    .out_bit(out_bit), .out_sfx(out_sfx)
  );

  // R7
  ovf_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(log_ovf) |-> log_cnt == DEPTH_L);

  // R7
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(log_ovf) |-> (state == ST_SCAN) && (log_cnt == '0));

  // R8
  blk_close_chk: assert property (@(posedge clk) disable iff (rst)
    accept && last |=> !in_ready);

  // R4
  skip_bound_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> 32'(skip_cnt) <= BLOCK_BITS);
endmodule

// File: tb/run_strip_condenser_tb.sv
module run_strip_condenser_tb;
  localparam int BLK   = 96;
  localparam int MIN   = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_bit, out_sfx, log_ovf;

  always #10 clk = ~clk;

  run_strip_condenser #(.BLOCK_BITS(BLK), .MIN_RUN(MIN), .LOG_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .out_valid(out_valid), .out_bit(out_bit), .out_sfx(out_sfx),
    .out_ready(out_ready), .log_ovf(log_ovf)
  );

  int n_chk = 0, n_fail = 0;
  logic blk [BLK];
  int fp;
  logic exp_pay [$];
  logic [19:0] exp_log [$];
  bit exp_ovf;
  int m_skip;
  logic cap_bit [$];
  logic cap_sfx [$];
  int sfx_seen = 0, exp_sfx_total = 0, r10_viol = 0;
  bit ovf_at_sfx = 0;
  bit bp_en = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_en ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (sfx_seen >= 1 && sfx_seen < exp_sfx_total - 1 && in_ready) r10_viol++;
      if (out_valid && out_ready) begin
        cap_bit.push_back(out_bit);
        cap_sfx.push_back(out_sfx);
        if (out_sfx) begin
          if (sfx_seen == 0) ovf_at_sfx = log_ovf;
          sfx_seen++;
        end
      end
    end
  end

  task automatic add_run(logic v, int n);
    for (int k = 0; k < n; k++) begin blk[fp] = v; fp++; end
  endtask

  task automatic add_alt(logic first);
    logic v = first;
    while (fp < BLK) begin blk[fp] = v; v = ~v; fp++; end
  endtask

  task automatic put_piece(logic v, int c);
    if (c >= MIN && exp_log.size() < DEPTH) begin
      exp_log.push_back({m_skip[13:0], c[4:0], v});
      m_skip = 0;
    end else begin
      if (c >= MIN) exp_ovf = 1;
      for (int k = 0; k < c; k++) exp_pay.push_back(v);
      m_skip += c;
    end
  endtask

  task automatic build_expect();
    int i = 0;
    exp_pay.delete(); exp_log.delete(); exp_ovf = 0; m_skip = 0;
    while (i < BLK) begin
      int j = i;
      int len;
      while (j + 1 < BLK && blk[j+1] == blk[i]) j++;
      len = j - i + 1;
      while (len >= 31) begin put_piece(blk[i], 31); len -= 31; end
      if (len > 0) put_piece(blk[i], len);
      i = j + 1;
    end
  endtask

  task automatic run_block(string name);
    int np, total, t, bad, first_bad, viol0;
    logic [19:0] w;
    logic [7:0] mk;
    build_expect();
    cap_bit.delete(); cap_sfx.delete();
    sfx_seen = 0; ovf_at_sfx = 0; viol0 = r10_viol;
    np = exp_pay.size();
    exp_sfx_total = 20 * exp_log.size() + 8;
    total = np + exp_sfx_total;
    for (int k = 0; k < BLK; k++) begin
      in_valid = 1'b1; in_bit = blk[k];
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    t = 0;
    while (cap_bit.size() < total && t < 20000) begin @(posedge clk); #1; t++; end
    $display("block %s: %0d payload, %0d entries", name, np, exp_log.size());
    chk(cap_bit.size() == total, "R3", {name, " output length"}, cap_bit.size(), total);
    if (cap_bit.size() == total) begin
      bad = 0; first_bad = -1;
      for (int k = 0; k < np; k++)
        if (cap_bit[k] !== exp_pay[k]) begin bad++; if (first_bad < 0) first_bad = k; end
      chk(bad == 0, "R2", {name, " payload mismatches (first index as actual)"}, first_bad, -1);
      bad = 0;
      for (int k = 0; k < total; k++) if (cap_sfx[k] !== (k >= np)) bad++;
      chk(bad == 0, "R6", {name, " suffix flag placement errors"}, bad, 0);
      for (int e = 0; e < exp_log.size(); e++) begin
        w = '0;
        for (int b = 0; b < 20; b++) w = {w[18:0], cap_bit[np + 20*e + b]};
        chk(w === exp_log[e], "R4", {name, " log entry"}, int'(w), int'(exp_log[e]));
      end
      mk = '0;
      for (int b = 0; b < 8; b++) mk = {mk[6:0], cap_bit[np + 20*exp_log.size() + b]};
      chk(mk === 8'hA5, "R6", {name, " end marker"}, int'(mk), 165);
    end
    chk(ovf_at_sfx == exp_ovf, "R7", {name, " overflow flag at suffix"}, ovf_at_sfx, exp_ovf);
    chk(log_ovf === 1'b0, "R7", {name, " overflow flag after marker"}, log_ovf, 0);
    chk(r10_viol == viol0, "R10", {name, " input ready during suffix"}, r10_viol - viol0, 0);
  endtask

  task automatic t_reset();
    chk(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready === 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(log_ovf === 1'b0, "R1", "log_ovf after reset", log_ovf, 0);
  endtask

  task automatic t_alternating();  // R3: nothing stripped
    fp = 0; add_alt(1'b0);
    bp_en = 0; run_block("alternating");
  endtask

  task automatic t_mixed();  // R2 R4 with stalls (R9)
    fp = 0;
    add_run(1'b1, 7); add_run(1'b0, 8); add_run(1'b1, 3); add_run(1'b0, 12);
    add_run(1'b1, 1); add_run(1'b0, 5); add_run(1'b1, 9); add_alt(1'b0);
    bp_en = 1; run_block("mixed");
  endtask

  task automatic t_long_short_tail();  // R5: remainder 3 passes
    fp = 0; add_run(1'b0, 65); add_alt(1'b1);
    bp_en = 0; run_block("long65");
  endtask

  task automatic t_long_kept_tail();  // R5: remainder 8 stripped
    fp = 0; add_run(1'b1, 70); add_alt(1'b0);
    bp_en = 1; run_block("long70");
  endtask

  task automatic t_all_ones();  // R5 R8: run ends at block end
    fp = 0; add_run(1'b1, BLK);
    bp_en = 0; run_block("all_ones");
  endtask

  task automatic t_overflow();  // R7
    fp = 0;
    for (int r = 0; r < 9; r++) add_run(r[0], 10);
    add_alt(1'b1);
    bp_en = 1; run_block("overflow");
  endtask

  task automatic t_boundary();  // R8: a run split by the block edge is not stripped
    fp = 0; add_alt(1'b1); fp = 91; add_run(1'b0, 5);
    bp_en = 0; run_block("edge_a");
    fp = 0; add_run(1'b0, 5); add_alt(1'b1);
    run_block("edge_b");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst = 1'b0;
    @(posedge clk); #1;
    t_alternating();
    t_mixed();
    t_long_short_tail();
    t_long_kept_tail();
    t_all_ones();
    t_overflow();
    t_boundary();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
    summary();
    $finish;
  end
endmodule